// File: doc/BRIEF.md
# Multi-Channel Fractional Tick Divider

This block turns one 500 Hz base tick strobe into four independent streams of periodic event pulses. Every channel holds a frequency-select code, an 8-bit tick down-counter and a 2-bit correction counter. Each base tick decrements every active channel. When a channel's count runs out, the block raises a one-cycle interrupt-request pulse on that channel's bit and reloads the counter from a fixed six-entry rate table.

Some rates do not divide 500 Hz evenly. For those, the correction counter stretches one period in every N by a single base tick. For 60 Hz this repeats periods of 8, 8 and 9 ticks, which gives three events per 25 base ticks.

Software or a controller chooses a channel's rate by writing a frequency in hertz on a small write port. The block checks each write against the table and against a lock that keeps the upper two channels running. It answers each write one cycle later with an acknowledge pulse or an error pulse. A combinational readback port shows the code, tick count and correction count of any channel.

Top module: `ratediv_top`

## Requirements
- R1: A channel's tick and correction counters change only in a cycle where `base_tick` is high or a write to that channel is accepted. An `irq` bit can be high only in the cycle right after a clock edge at which `base_tick` was high.
- R2: The rate table maps each write value to a code, a reload count and a correction reload:

  | Hz written | Code | Reload | Correction |
  |---|---|---|---|
  | 0 | 0 (off) | 0 | 0 |
  | 500 | 1 | 1 | 0 |
  | 50 | 2 | 10 | 0 |
  | 60 | 3 | 8 | 3 |
  | 100 | 4 | 5 | 0 |
  | 2 | 5 | 250 | 0 |

- R3: A channel whose tick count is 0 does not decrement and does not raise its `irq` bit.
- R4: At each base tick an active channel's count decrements. When the count reaches 0, the channel's `irq` bit is high for exactly the next cycle and the count reloads from the table entry for its code.
- R5: When a channel expires with a nonzero correction count, that count decrements. If it reaches 0, the reloaded tick count is one higher and the correction count reloads. After a 60 Hz write, the tick periods between events are therefore 8, 8, 8, 9, then 8, 8, 9 repeating.
- R6: After reset:
  - channels 0 and 1 have code 0 and count 0;
  - channels 2 and 3 have code 1 and count 1;
  - every correction count is 0;
  - `irq`, `wr_ack` and `wr_err` are low.
- R7: For an accepted write, `wr_ack` is high for exactly the next cycle. The written channel takes the new code and loads its tick and correction counts from the table. If a base tick arrives in the same cycle, that channel does not advance and does not fire.
- R8: A write is rejected in either of two cases: the value is not in the table, or the value is 0 Hz for channel 2 or 3. A rejected write sets `wr_err` high for exactly the next cycle and leaves all channel state unchanged. Without a write, `wr_ack` and `wr_err` stay low.
- R9: `rd_code`, `rd_count` and `rd_corr` show the current code, tick count and correction count of the channel selected by `rd_ch`, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| base_tick | input | 1 | One-cycle strobe at the 500 Hz base rate |
| wr_en | input | 1 | Rate write request |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_hz | input | 10 | Requested frequency in Hz |
| wr_ack | output | 1 | Write accepted (pulse, one cycle after the write) |
| wr_err | output | 1 | Write rejected (pulse, one cycle after the write) |
| rd_ch | input | 2 | Channel selected for readback |
| rd_code | output | 3 | Frequency code of the selected channel |
| rd_count | output | 8 | Tick count of the selected channel |
| rd_corr | output | 2 | Correction count of the selected channel |
| irq | output | 4 | Per-channel event pulse |

## Verification
The assertions assume the following about the inputs:
- `base_tick` and the write inputs are driven at known levels.
- No write arrives during the two cycles in which the synchronised reset is still settling. The response checks are off until that window ends.

The stimulus respects these assumptions in three ways:
- It changes every input only on the falling clock edge.
- It keeps all inputs quiet for several cycles after reset is released.
- It mixes directed cases with a long random phase. The random phase uses irregular tick gaps and writes that include out-of-table values and forbidden off requests.

// File: rtl/ratediv_pkg.sv
package ratediv_pkg;

  localparam int FS_NUM    = 6;
  localparam int FS_CODE_W = 3;
  localparam int FS_CNT_W  = 8;
  localparam int FS_COR_W  = 2;
  localparam int FS_HZ_W   = 10;

  typedef enum logic [FS_CODE_W-1:0] {
    FS_OFF = 3'd0,
    FS_500 = 3'd1,
    FS_50  = 3'd2,
    FS_60  = 3'd3,
    FS_100 = 3'd4,
    FS_2   = 3'd5
  } fsel_e;

  // Output rate in Hz for each code
  function automatic logic [FS_HZ_W-1:0] fs_hz(input fsel_e c);
    case (c)
      FS_500:  return 10'd500;
      FS_50:   return 10'd50;
      FS_60:   return 10'd60;
      FS_100:  return 10'd100;
      FS_2:    return 10'd2;
      default: return 10'd0;
    endcase
  endfunction

  // Base ticks per period (before correction)
  function automatic logic [FS_CNT_W-1:0] fs_reload(input fsel_e c);
    case (c)
      FS_500:  return 8'd1;
      FS_50:   return 8'd10;
      FS_60:   return 8'd8;
      FS_100:  return 8'd5;
      FS_2:    return 8'd250;
      default: return 8'd0;
    endcase
  endfunction

  // Periods between stretched periods
  function automatic logic [FS_COR_W-1:0] fs_corr(input fsel_e c);
    case (c)
      FS_60:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ratediv_rstsync.sv
module ratediv_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ratediv_decode.sv
module ratediv_decode
  import ratediv_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_FREE = 2,
  parameter int HZ_W     = FS_HZ_W,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [HZ_W-1:0] wr_hz,
  output logic            accept,
  output logic            reject,
  output fsel_e           code
);

  logic hit;
  logic locked;

  // Table search: first matching entry wins
  always_comb begin
    hit  = 1'b0;
    code = FS_OFF;
    for (int i = 0; i < FS_NUM; i++) begin
      if (!hit && (wr_hz == HZ_W'(fs_hz(fsel_e'(FS_CODE_W'(i)))))) begin
        hit  = 1'b1;
        code = fsel_e'(FS_CODE_W'(i));
      end
    end
  end

  // Upper channels may not be switched off
  assign locked = (code == FS_OFF) && (wr_ch >= CH_W'(NUM_FREE));
  assign accept = wr_en && hit && !locked;
  assign reject = wr_en && !accept;

endmodule

// File: rtl/ratediv_chan.sv
module ratediv_chan
  import ratediv_pkg::*;
#(
  parameter int    CNT_W    = FS_CNT_W,
  parameter int    COR_W    = FS_COR_W,
  parameter fsel_e RST_CODE = FS_OFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  fsel_e            load_code,
  output fsel_e            code_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [COR_W-1:0] cor_q,
  output logic             irq_q
);

  fsel_e            code_d;
  logic [CNT_W-1:0] cnt_d;
  logic [COR_W-1:0] cor_d;
  logic [CNT_W-1:0] dec;
  logic             fire_d;
  logic             en;

  always_comb begin
    code_d = code_q;
    cnt_d  = cnt_q;
    cor_d  = cor_q;
    fire_d = 1'b0;
    en     = 1'b0;
    dec    = cnt_q - 1'b1;
    if (load) begin
      en     = 1'b1;
      code_d = load_code;
      cnt_d  = CNT_W'(fs_reload(load_code));
      cor_d  = COR_W'(fs_corr(load_code));
    end else if (tick && (cnt_q != '0)) begin
      en = 1'b1;
      if (dec == '0) begin
        fire_d = 1'b1;
        cnt_d  = CNT_W'(fs_reload(code_q));
        if (cor_q != '0) begin
          cor_d = cor_q - 1'b1;
          if (cor_q == COR_W'(1)) begin
            cnt_d = CNT_W'(fs_reload(code_q)) + 1'b1;
            cor_d = COR_W'(fs_corr(code_q));
          end
        end
      end else begin
        cnt_d = dec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      cnt_q  <= CNT_W'(fs_reload(RST_CODE));
      cor_q  <= COR_W'(fs_corr(RST_CODE));
      irq_q  <= 1'b0;
    end else begin
      if (en) begin
        code_q <= code_d;
        cnt_q  <= cnt_d;
        cor_q  <= cor_d;
      end
      irq_q <= fire_d;
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !load) |=> !irq_q); // R3

  AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick && !load)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(cnt_q) && $stable(cor_q))); // R1

  AST_ACTIVE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != FS_OFF) |-> (cnt_q != '0)); // R4

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == FS_OFF) |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/ratediv_top.sv
module ratediv_top
  import ratediv_pkg::*;
#(
  parameter int  NUM_CH   = 4,
  parameter int  NUM_FREE = 2,
  parameter int  HZ_W     = FS_HZ_W,
  parameter int  CNT_W    = FS_CNT_W,
  parameter int  COR_W    = FS_COR_W,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int CODE_W   = FS_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [HZ_W-1:0]   wr_hz,
  output logic              wr_ack,
  output logic              wr_err,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [CODE_W-1:0] rd_code,
  output logic [CNT_W-1:0]  rd_count,
  output logic [COR_W-1:0]  rd_corr,
  output logic [NUM_CH-1:0] irq
);

  logic              rst_s;
  logic              accept;
  logic              reject;
  fsel_e             new_code;
  logic [NUM_CH-1:0] ld;
  logic              ack_d, ack_q;
  logic              err_d, err_q;

  fsel_e             code_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [COR_W-1:0]  cor_a  [NUM_CH];

  ratediv_rstsync #(.STAGES(2)) i_rstsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  ratediv_decode #(
    .NUM_CH   (NUM_CH),
    .NUM_FREE (NUM_FREE),
    .HZ_W     (HZ_W)
  ) i_decode (
    .wr_en  (wr_en),
    .wr_ch  (wr_ch),
    .wr_hz  (wr_hz),
    .accept (accept),
    .reject (reject),
    .code   (new_code)
  );

  always_comb begin
    ld = '0;
    if (accept) ld[wr_ch] = 1'b1;
    ack_d = accept;
    err_d = reject;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ack_d;
      err_q <= err_d;
    end
  end

  assign wr_ack = ack_q;
  assign wr_err = err_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam fsel_e RST_SEL = (g < NUM_FREE) ? FS_OFF : FS_500;

    ratediv_chan #(
      .CNT_W    (CNT_W),
      .COR_W    (COR_W),
      .RST_CODE (RST_SEL)
    ) i_chan (
      .clk       (clk),
      .rst_n     (rst_s),
      .tick      (base_tick),
      .load      (ld[g]),
      .load_code (new_code),
      .code_q    (code_a[g]),
      .cnt_q     (cnt_a[g]),
      .cor_q     (cor_a[g]),
      .irq_q     (irq[g])
    );

    if (g >= NUM_FREE) begin : g_lock
      AST_LOCKED_ON: assert property (@(posedge clk) disable iff (!rst_s)
        code_a[g] != FS_OFF); // R8
    end
  end

  assign rd_code  = code_a[rd_ch];
  assign rd_count = cnt_a[rd_ch];
  assign rd_corr  = cor_a[rd_ch];

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> (wr_ack != wr_err)); // R7

  AST_QUIET_PORT: assert property (@(posedge clk) disable iff (!rst_s)
    !wr_en |=> (!wr_ack && !wr_err)); // R8

endmodule

// File: tb/test_ratediv_top.sv
module test_ratediv_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [9:0] wr_hz = '0;
  logic [1:0] rd_ch = '0;
  logic       wr_ack, wr_err;
  logic [2:0] rd_code;
  logic [7:0] rd_count;
  logic [1:0] rd_corr;
  logic [3:0] irq;

  // 20-unit period: 50 MHz with 1 ns units
  always #10 clk = ~clk;

  ratediv_top i_ratediv_top (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_hz(wr_hz),
    .wr_ack(wr_ack), .wr_err(wr_err),
    .rd_ch(rd_ch), .rd_code(rd_code), .rd_count(rd_count), .rd_corr(rd_corr),
    .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit auto_rd = 1'b0;

  int hz_tab [6] = '{0, 500, 50, 60, 100, 2};
  int rl_tab [6] = '{0, 1, 10, 8, 5, 250};
  int cr_tab [6] = '{0, 0, 0, 3, 0, 0};
  int rnd_hz [10] = '{0, 500, 50, 60, 100, 2, 7, 1000, 499, 61};

  int       m_code [4];
  int       m_cnt  [4];
  int       m_cor  [4];
  bit [3:0] m_irq;
  bit       m_ack, m_err;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int  idx;
    bit  ok;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_code[c] = (c < 2) ? 0 : 1;
        m_cnt[c]  = rl_tab[m_code[c]];
        m_cor[c]  = 0;
      end
      m_irq = '0; m_ack = 0; m_err = 0;
    end else begin
      idx = -1;
      for (int i = 0; i < 6; i++) if (idx < 0 && hz_tab[i] == int'(wr_hz)) idx = i;
      ok    = wr_en && (idx >= 0) && !(idx == 0 && wr_ch >= 2);
      m_ack = ok;
      m_err = wr_en && !ok;
      m_irq = '0;
      for (int c = 0; c < 4; c++) begin
        if (ok && int'(wr_ch) == c) begin
          m_code[c] = idx; m_cnt[c] = rl_tab[idx]; m_cor[c] = cr_tab[idx];
        end else if (base_tick && m_cnt[c] != 0) begin
          m_cnt[c]--;
          if (m_cnt[c] == 0) begin
            m_irq[c] = 1'b1;
            m_cnt[c] = rl_tab[m_code[c]];
            if (m_cor[c] != 0) begin
              m_cor[c]--;
              if (m_cor[c] == 0) begin
                m_cnt[c]++;
                m_cor[c] = cr_tab[m_code[c]];
              end
            end
          end
        end
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    check(irq == m_irq, "R4 irq", irq, m_irq);
    check(wr_ack == m_ack, "R7 ack", wr_ack, m_ack);
    check(wr_err == m_err, "R8 err", wr_err, m_err);
    check(int'(rd_code) == m_code[rd_ch], "R9 code", rd_code, m_code[rd_ch]);
    check(int'(rd_count) == m_cnt[rd_ch], "R9 count", rd_count, m_cnt[rd_ch]);
    check(int'(rd_corr) == m_cor[rd_ch], "R9 corr", rd_corr, m_cor[rd_ch]);
  end

  always @(negedge clk) if (auto_rd) rd_ch <= rd_ch + 2'd1;

  task automatic drive(input bit t, input bit we, input int ch, input int hz);
    @(negedge clk);
    base_tick = t; wr_en = we; wr_ch = ch[1:0]; wr_hz = hz[9:0];
    @(posedge clk);
    #5;
  endtask

  task automatic peek(input int ch, output int c, output int n, output int r);
    rd_ch = ch[1:0];
    #1;
    c = rd_code; n = rd_count; r = rd_corr;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int c, n, r, c0, n0, r0, gap;
    int exp_gap [7] = '{8, 8, 8, 9, 8, 8, 9};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) drive(0, 0, 0, 0);

    // R6: reset state
    for (int ch = 0; ch < 4; ch++) begin
      peek(ch, c, n, r);
      check(c == ((ch < 2) ? 0 : 1), "R6 code", c, (ch < 2) ? 0 : 1);
      check(n == ((ch < 2) ? 0 : 1), "R6 count", n, (ch < 2) ? 0 : 1);
      check(r == 0, "R6 corr", r, 0);
    end
    check(irq == 4'b0 && !wr_ack && !wr_err, "R6 outputs", {irq, wr_ack, wr_err}, 0);

    // R1: no base ticks, nothing moves
    for (int k = 0; k < 20; k++) begin
      drive(0, 0, 0, 0);
      check(irq == 4'b0, "R1 no tick irq", irq, 0);
    end
    peek(2, c, n, r);
    check(n == 1, "R1 count held", n, 1);

    // R2: every table entry loads on channel 0
    for (int code = 1; code < 6; code++) begin
      drive(0, 1, 0, hz_tab[code]);
      check(wr_ack == 1'b1, "R2 ack", wr_ack, 1);
      peek(0, c, n, r);
      check(c == code, "R2 code", c, code);
      check(n == rl_tab[code], "R2 reload", n, rl_tab[code]);
      check(r == cr_tab[code], "R2 corr", r, cr_tab[code]);
    end

    // R3: channel 0 switched off stays silent
    drive(0, 1, 0, 0);
    for (int k = 0; k < 30; k++) begin
      drive(1, 0, 0, 0);
      check(irq[0] == 1'b0, "R3 off irq", irq[0], 0);
    end
    peek(0, c, n, r);
    check(n == 0, "R3 off count", n, 0);

    // R4: 100 Hz fires on the fifth tick
    drive(0, 1, 0, 100);
    for (int k = 0; k < 6; k++) begin
      drive(1, 0, 0, 0);
      check(irq[0] == (k == 4), "R4 period", irq[0], k == 4);
    end

    // R5: 60 Hz period sequence
    drive(0, 1, 1, 60);
    for (int k = 0; k < 7; k++) begin
      gap = 0;
      do begin
        drive(1, 0, 0, 0);
        gap++;
      end while (!irq[1] && gap < 20);
      check(gap == exp_gap[k], "R5 gap", gap, exp_gap[k]);
    end

    // R7: write and tick in the same cycle on an active channel
    drive(1, 1, 2, 50);
    check(irq[2] == 1'b0, "R7 collision irq", irq[2], 0);
    peek(2, c, n, r);
    check(c == 2 && n == 10, "R7 collision load", n, 10);

    // R8: rejected writes leave state unchanged
    peek(3, c0, n0, r0);
    drive(0, 1, 3, 0);
    check(wr_err == 1'b1 && wr_ack == 1'b0, "R8 lock err", wr_err, 1);
    peek(3, c, n, r);
    check(c == c0 && n == n0 && r == r0, "R8 lock state", c, c0);
    peek(0, c0, n0, r0);
    drive(0, 1, 0, 33);
    check(wr_err == 1'b1, "R8 bad hz err", wr_err, 1);
    peek(0, c, n, r);
    check(c == c0 && n == n0 && r == r0, "R8 bad hz state", n, n0);
    drive(0, 1, 2, 1000);
    check(wr_err == 1'b1, "R8 range err", wr_err, 1);

    // Random phase, compared every cycle against the model
    auto_rd = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      drive(($urandom % 3) != 0, ($urandom % 20) == 0,
            int'($urandom % 4), rnd_hz[$urandom % 10]);
    end
    drive(0, 0, 0, 0);
    finish_run();
  end

endmodule